// File: doc/BRIEF.md
# NAND Block-Erase Command Target

This block is the device side of an 8-bit NAND-style command bus, reduced to block erase on a small internal byte array. A host presents bytes on `io_in` and marks each one as a command (`cle`) or an address byte (`ale`). Each byte takes effect on the rising edge of `we`. The erase setup opcode arms the sequencer. Three address bytes then form a row value, and the confirm opcode starts the erase. `rdy` goes low for a number of clock cycles that the host chooses through `erase_time`. At the end, every byte of the selected block becomes FFh, unless the test input `force_fail` was high at the confirm.

The status opcode routes an 8-bit status register onto `io_out`. Bit 6 of the status register shows that the block is ready. Bit 0 reports the result of the last erase. While an erase runs, only the status opcode and the reset opcode are acted on. All other bus traffic is dropped. The reset opcode cancels an erase at any point.

A load port fills the array and a peek port reads it. With these ports, the array contents before and after an erase can be set and observed.

Top module: `nand_erase_target`

## Requirements
- R1: After `rst_n` is released, `rdy` is 1, `io_out` is 00h, every array byte is 00h, and the status register holds 40h.
- R2: Setup opcode 60h, followed by three address bytes, forms a 24-bit row: the first byte is bits 7:0, the second is bits 15:8 and the third is bits 23:16. The block number is row bits [PAGE_BITS+BLK_BITS-1:PAGE_BITS]. All other row bits have no effect.
- R3: Confirm opcode D0h, arriving after the third address byte, makes `rdy` go low from the clock edge that samples the rising edge of `we`.
- R4: A passing erase writes FFh to all 2^WPB_BITS bytes of the selected block. No other block changes.
- R5: While busy, any command other than 70h or FFh, and any address byte, has no effect: the sequence, the timer and the status selection stay as they were.
- R6: Busy lasts `erase_time` clock cycles, and a value of 0 counts as 1. Status bit 6 reads 0 while busy and 1 otherwise, and always equals `rdy`.
- R7: Command 70h makes `io_out` show the status register. Any other command that is acted on while not busy returns `io_out` to 00h.
- R8: Status bit 0 is 0 after a passing erase. It is 1 when `force_fail` was high at the confirm edge. A failing erase leaves the array unchanged.
- R9: Any command other than D0h during the address phase or in the confirm slot aborts the sequence to idle, with no erase.
- R10: Command FFh in any state returns the block to idle with `rdy` 1 and status 40h, and cancels a running erase without writing the array.
- R11: Bus bytes act only on a rising edge of `we`. Holding `we` high while `io_in` changes has no effect.
- R12: `ld_en` writes `ld_data` to array address `ld_addr` on the clock edge, and `pk_data` shows the byte at `pk_addr` combinationally. An erase fill takes priority over a load to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Bus write strobe; a byte acts on its rising edge |
| cle | input | 1 | Marks the byte as a command |
| ale | input | 1 | Marks the byte as an address byte |
| io_in | input | 8 | Bus byte from host |
| io_out | output | 8 | Status register when selected, else 00h |
| rdy | output | 1 | High when ready, low while erasing |
| erase_time | input | TIME_W | Busy length in cycles, latched at confirm |
| force_fail | input | 1 | Test input: makes the erase fail, latched at confirm |
| ld_en | input | 1 | Array load enable |
| ld_addr | input | BLK_BITS+WPB_BITS | Array load address |
| ld_data | input | 8 | Array load byte |
| pk_addr | input | BLK_BITS+WPB_BITS | Array peek address |
| pk_data | output | 8 | Array peek byte |

## Verification
The bench builds the block with BLK_BITS=2, WPB_BITS=2 and TIME_W=4. With these values the array has 16 bytes, so every byte is compared against the model on every clock. Busy lengths from the zero-means-one case up to the maximum of 15 can be reached in a few cycles each. PAGE_BITS stays at 6, and the bench sets the page bits and the row bits above the block field to ones. This shows that only the block field chooses what is erased.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_CONF = 2'd2,
    ST_BUSY = 2'd3
  } seq_state_t;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  localparam int ROW_W = 24;
  localparam logic [7:0] STATUS_IDLE = 8'h40;

  // Insert one address byte into the row at the slot given by idx.
  function automatic logic [ROW_W-1:0] row_merge(input logic [ROW_W-1:0] row,
                                                 input logic [1:0] idx,
                                                 input logic [7:0] b);
    logic [ROW_W-1:0] r;
    r = row;
    case (idx)
      2'd0:    r[7:0]   = b;
      2'd1:    r[15:8]  = b;
      default: r[23:16] = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ne_we_edge.sv
module ne_we_edge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       cle,
  input  logic       ale,
  input  logic [7:0] io_in,
  output logic       cmd_stb,
  output logic       addr_stb,
  output logic [7:0] bus_byte
);
  logic we_q;
  logic we_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we;
  end

  assign we_rise  = we && !we_q;
  assign cmd_stb  = we_rise && cle;
  assign addr_stb = we_rise && ale && !cle;
  assign bus_byte = io_in;

  // R11: a strobe never repeats on the following cycle
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb || addr_stb) |=> !(cmd_stb || addr_stb));

endmodule

// File: rtl/ne_erase_seq.sv
module ne_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLK_BITS  = 3,
  parameter int PAGE_BITS = 6,
  parameter int TIME_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_stb,
  input  logic                addr_stb,
  input  logic [7:0]          bus_byte,
  input  logic [TIME_W-1:0]   erase_time,
  input  logic                force_fail,
  output logic                rdy,
  output logic [7:0]          status,
  output logic                stat_sel,
  output logic                erase_go,
  output logic [BLK_BITS-1:0] erase_blk
);
  seq_state_t          state;
  logic [1:0]          idx_q;
  logic [ROW_W-1:0]    row_q;
  logic [TIME_W-1:0]   cnt_q;
  logic                fail_q;
  logic [BLK_BITS-1:0] blk_q;
  logic                ready_bit;
  logic                fail_bit;

  // named internal events
  logic ev_reset, ev_status, ev_arm, ev_addr, ev_confirm, ev_abort, ev_done;
  logic ev_other_cmd;

  function automatic logic [TIME_W-1:0] load_count(input logic [TIME_W-1:0] t);
    return (t == '0) ? TIME_W'(1) : t;
  endfunction

  function automatic logic [BLK_BITS-1:0] block_of(input logic [ROW_W-1:0] row);
    return row[PAGE_BITS +: BLK_BITS];
  endfunction

  assign ev_reset     = cmd_stb && (bus_byte == OP_RESET);
  assign ev_status    = cmd_stb && (bus_byte == OP_STATUS);
  assign ev_arm       = (state == ST_IDLE) && cmd_stb && (bus_byte == OP_ERASE_SETUP);
  assign ev_addr      = (state == ST_ADDR) && addr_stb;
  assign ev_confirm   = (state == ST_CONF) && cmd_stb && (bus_byte == OP_ERASE_GO);
  assign ev_abort     = ((state == ST_ADDR) || (state == ST_CONF)) && cmd_stb && !ev_confirm;
  assign ev_done      = (state == ST_BUSY) && (cnt_q == TIME_W'(1)) && !ev_reset;
  assign ev_other_cmd = cmd_stb && !ev_status && (state != ST_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx_q     <= 2'd0;
      row_q     <= '0;
      cnt_q     <= '0;
      fail_q    <= 1'b0;
      blk_q     <= '0;
      ready_bit <= 1'b1;
      fail_bit  <= 1'b0;
      stat_sel  <= 1'b0;
    end else if (ev_reset) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      ready_bit <= 1'b1;
      fail_bit  <= 1'b0;
      stat_sel  <= 1'b0;
    end else begin
      if (ev_status)         stat_sel <= 1'b1;
      else if (ev_other_cmd) stat_sel <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ev_arm) begin
            state <= ST_ADDR;
            idx_q <= 2'd0;
            row_q <= '0;
          end
        end
        ST_ADDR: begin
          if (ev_abort) begin
            state <= ST_IDLE;
          end else if (ev_addr) begin
            row_q <= row_merge(row_q, idx_q, bus_byte);
            if (idx_q == 2'd2) state <= ST_CONF;
            else               idx_q <= idx_q + 2'd1;
          end
        end
        ST_CONF: begin
          if (ev_confirm) begin
            state     <= ST_BUSY;
            cnt_q     <= load_count(erase_time);
            fail_q    <= force_fail;
            blk_q     <= block_of(row_q);
            ready_bit <= 1'b0;
          end else if (ev_abort) begin
            state <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (ev_done) begin
            state     <= ST_IDLE;
            ready_bit <= 1'b1;
            fail_bit  <= fail_q;
          end else begin
            cnt_q <= cnt_q - TIME_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rdy       = (state != ST_BUSY);
  assign status    = {1'b0, ready_bit, 5'b0, fail_bit};
  assign erase_go  = ev_done && !fail_q;
  assign erase_blk = blk_q;

  // R6: ready output and status bit 6 always agree
  a_r6_rdy_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy == status[6]);

  // R6: the busy timer steps down by one per cycle
  a_r6_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BUSY) && (cnt_q > TIME_W'(1)) && !ev_reset) |=>
      (cnt_q == $past(cnt_q) - TIME_W'(1)) && !rdy);

  // R3: confirm makes the block busy on the next cycle
  a_r3_confirm_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_confirm && !ev_reset |=> !rdy);

  // R9: an aborted sequence lands in idle, ready
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && !ev_reset) |=> (state == ST_IDLE) && rdy);

  // R5: ignored commands while busy leave the status selection alone
  a_r5_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BUSY) && cmd_stb && !ev_status && !ev_reset) |=> $stable(stat_sel));

  // R10: reset command yields idle status
  a_r10_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> rdy && (status == STATUS_IDLE) && !stat_sel);

endmodule

// File: rtl/ne_block_array.sv
module ne_block_array #(
  parameter int BLK_BITS = 3,
  parameter int WPB_BITS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         erase_go,
  input  logic [BLK_BITS-1:0]          erase_blk,
  input  logic                         ld_en,
  input  logic [BLK_BITS+WPB_BITS-1:0] ld_addr,
  input  logic [7:0]                   ld_data,
  input  logic [BLK_BITS+WPB_BITS-1:0] pk_addr,
  output logic [7:0]                   pk_data
);
  localparam int AW    = BLK_BITS + WPB_BITS;
  localparam int DEPTH = 1 << AW;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] fill_hit;
  logic [DEPTH-1:0] load_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_decode
    assign fill_hit[g] = erase_go && (erase_blk == BLK_BITS'(g >> WPB_BITS));
    assign load_hit[g] = ld_en && (ld_addr == AW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill_hit[i])      mem[i] <= 8'hFF;
        else if (load_hit[i]) mem[i] <= ld_data;
      end
    end
  end

  assign pk_data = mem[pk_addr];

  // R4: after a fill the first byte of the block reads all ones
  a_r4_block_filled: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem[{$past(erase_blk), {WPB_BITS{1'b0}}}] == 8'hFF));

  // R4: after a fill the last byte of the block reads all ones
  a_r4_block_last: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem[{$past(erase_blk), {WPB_BITS{1'b1}}}] == 8'hFF));

endmodule

// File: rtl/nand_erase_target.sv
module nand_erase_target #(
  parameter int BLK_BITS  = 3,
  parameter int WPB_BITS  = 2,
  parameter int PAGE_BITS = 6,
  parameter int TIME_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic                         cle,
  input  logic                         ale,
  input  logic [7:0]                   io_in,
  output logic [7:0]                   io_out,
  output logic                         rdy,
  input  logic [TIME_W-1:0]            erase_time,
  input  logic                         force_fail,
  input  logic                         ld_en,
  input  logic [BLK_BITS+WPB_BITS-1:0] ld_addr,
  input  logic [7:0]                   ld_data,
  input  logic [BLK_BITS+WPB_BITS-1:0] pk_addr,
  output logic [7:0]                   pk_data
);
  logic                cmd_stb, addr_stb;
  logic [7:0]          bus_byte;
  logic [7:0]          status;
  logic                stat_sel;
  logic                erase_go;
  logic [BLK_BITS-1:0] erase_blk;

  ne_we_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .cle      (cle),
    .ale      (ale),
    .io_in    (io_in),
    .cmd_stb  (cmd_stb),
    .addr_stb (addr_stb),
    .bus_byte (bus_byte)
  );

  ne_erase_seq #(
    .BLK_BITS  (BLK_BITS),
    .PAGE_BITS (PAGE_BITS),
    .TIME_W    (TIME_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb    (cmd_stb),
    .addr_stb   (addr_stb),
    .bus_byte   (bus_byte),
    .erase_time (erase_time),
    .force_fail (force_fail),
    .rdy        (rdy),
    .status     (status),
    .stat_sel   (stat_sel),
    .erase_go   (erase_go),
    .erase_blk  (erase_blk)
  );

  ne_block_array #(
    .BLK_BITS (BLK_BITS),
    .WPB_BITS (WPB_BITS)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_go  (erase_go),
    .erase_blk (erase_blk),
    .ld_en     (ld_en),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .pk_addr   (pk_addr),
    .pk_data   (pk_data)
  );

  assign io_out = stat_sel ? status : 8'h00;

  // R7: the output bus is zero unless status is selected
  a_r7_out_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_sel |-> (io_out == 8'h00));

endmodule

// File: tb/nand_erase_target_tb.sv
module nand_erase_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_BITS   = 2;
  localparam int WPB_BITS   = 2;
  localparam int PAGE_BITS  = 6;
  localparam int TIME_W     = 4;
  localparam int AW         = BLK_BITS + WPB_BITS;
  localparam int DEPTH      = 1 << AW;
  localparam int WPB        = 1 << WPB_BITS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0, cle = 1'b0, ale = 1'b0;
  logic [7:0]        io_in = 8'h00;
  logic [7:0]        io_out;
  logic              rdy;
  logic [TIME_W-1:0] erase_time = '0;
  logic              force_fail = 1'b0;
  logic              ld_en = 1'b0;
  logic [AW-1:0]     ld_addr = '0;
  logic [7:0]        ld_data = 8'h00;
  logic [AW-1:0]     pk_addr = '0;
  logic [7:0]        pk_data;

  int n_checks = 0;
  int n_fail   = 0;
  int busy_cnt = 0;
  bit run_cmp  = 1'b0;

  nand_erase_target #(
    .BLK_BITS (BLK_BITS), .WPB_BITS (WPB_BITS),
    .PAGE_BITS (PAGE_BITS), .TIME_W (TIME_W)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .we (we), .cle (cle), .ale (ale),
    .io_in (io_in), .io_out (io_out), .rdy (rdy),
    .erase_time (erase_time), .force_fail (force_fail),
    .ld_en (ld_en), .ld_addr (ld_addr), .ld_data (ld_data),
    .pk_addr (pk_addr), .pk_data (pk_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_phase;   // 0 idle, 1 address, 2 confirm slot, 3 erasing
  int m_nbytes, m_row, m_left, m_blk;
  bit m_fail, m_ready, m_lastfail, m_sel, m_prev_we;
  int m_mem [DEPTH];

  always @(posedge clk) begin
    bit edge_seen, is_cmd, is_addr;
    if (!rst_n) begin
      m_phase = 0; m_nbytes = 0; m_row = 0; m_left = 0; m_blk = 0;
      m_fail = 0; m_ready = 1; m_lastfail = 0; m_sel = 0; m_prev_we = 0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    end else begin
      edge_seen = we && !m_prev_we;
      m_prev_we = we;
      is_cmd  = edge_seen && cle;
      is_addr = edge_seen && ale && !cle;
      if (ld_en) m_mem[int'(ld_addr)] = int'(ld_data);
      if (is_cmd && io_in == 8'hFF) begin
        m_phase = 0; m_ready = 1; m_lastfail = 0; m_sel = 0; m_left = 0;
      end else begin
        if (is_cmd && io_in == 8'h70) m_sel = 1;
        else if (is_cmd && m_phase != 3) m_sel = 0;
        if (m_phase == 0) begin
          if (is_cmd && io_in == 8'h60) begin m_phase = 1; m_nbytes = 0; m_row = 0; end
        end else if (m_phase == 1) begin
          if (is_cmd) m_phase = 0;
          else if (is_addr) begin
            m_row = m_row + (int'(io_in) << (8 * m_nbytes));
            m_nbytes++;
            if (m_nbytes == 3) m_phase = 2;
          end
        end else if (m_phase == 2) begin
          if (is_cmd && io_in == 8'hD0) begin
            m_phase = 3;
            m_left  = (erase_time == 0) ? 1 : int'(erase_time);
            m_fail  = force_fail;
            m_blk   = (m_row / (1 << PAGE_BITS)) % (1 << BLK_BITS);
            m_ready = 0;
          end else if (is_cmd) m_phase = 0;
        end else begin
          if (m_left == 1) begin
            m_phase = 0; m_ready = 1; m_lastfail = m_fail;
            if (!m_fail) for (int w = 0; w < WPB; w++) m_mem[m_blk * WPB + w] = 255;
          end else m_left--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (run_cmp) begin
      int exp_out;
      exp_out = m_sel ? ((m_ready ? 64 : 0) + (m_lastfail ? 1 : 0)) : 0;
      check(rdy == m_ready, "R6 rdy vs model", int'(rdy), int'(m_ready));
      check(int'(io_out) == exp_out, "R7 io_out vs model", int'(io_out), exp_out);
      check(int'(pk_data) == m_mem[int'(pk_addr)], "R12 pk_data vs model",
            int'(pk_data), m_mem[int'(pk_addr)]);
    end
    if (!rdy) busy_cnt++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_cmd(input logic [7:0] b);
    cle = 1'b1; ale = 1'b0; io_in = b; we = 1'b1; tick();
    we = 1'b0; cle = 1'b0; tick();
  endtask

  task automatic bus_addr(input logic [7:0] b);
    ale = 1'b1; cle = 1'b0; io_in = b; we = 1'b1; tick();
    we = 1'b0; ale = 1'b0; tick();
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 64 && !rdy; k++) tick();
    tick();
  endtask

  task automatic start_erase(input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int t);
    erase_time = TIME_W'(t);
    bus_cmd(8'h60); bus_addr(b0); bus_addr(b1); bus_addr(b2);
    busy_cnt = 0;
    bus_cmd(8'hD0);
  endtask

  task automatic peek(input int a, input int exp, input string req);
    pk_addr = AW'(a); #1;
    check(int'(pk_data) == exp, req, int'(pk_data), exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    run_cmp = 1'b1;
    tick();
    // R1: reset state
    check(rdy == 1'b1, "R1 rdy after reset", int'(rdy), 1);
    check(io_out == 8'h00, "R1 io_out after reset", int'(io_out), 0);
    peek(5, 0, "R1 array cleared");
    bus_cmd(8'h70);
    check(io_out == 8'h40, "R1 R7 status after reset", int'(io_out), 'h40);

    // R12: preload array
    for (int i = 0; i < DEPTH; i++) begin
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = 8'(i * 7 + 3); tick();
    end
    ld_en = 1'b0; tick();
    peek(9, 9 * 7 + 3, "R12 load then peek");

    // R2 R3 R4 R6: erase block 1, page and upper row bits all set
    start_erase(8'h7F, 8'hFF, 8'hFF, 5);
    check(rdy == 1'b0, "R3 busy after confirm", int'(rdy), 0);
    wait_ready();
    check(busy_cnt == 5, "R6 busy length 5", busy_cnt, 5);
    bus_cmd(8'h70);
    check(io_out == 8'h40, "R8 pass status", int'(io_out), 'h40);
    for (int w = 0; w < WPB; w++) peek(WPB + w, 255, "R4 block 1 filled");
    peek(0, 3, "R2 R4 block 0 untouched");
    peek(2 * WPB, 2 * WPB * 7 + 3, "R2 R4 block 2 untouched");

    // R8: forced failure on block 2
    force_fail = 1'b1;
    start_erase(8'h80, 8'h00, 8'h00, 3);
    force_fail = 1'b0;
    wait_ready();
    bus_cmd(8'h70);
    check(io_out == 8'h41, "R8 fail status", int'(io_out), 'h41);
    peek(2 * WPB + 1, (2 * WPB + 1) * 7 + 3, "R8 failed erase keeps data");

    // R9: abort in address phase and in confirm slot
    busy_cnt = 0;
    bus_cmd(8'h60); bus_addr(8'hC0); bus_cmd(8'h00);
    bus_addr(8'h00); bus_addr(8'h00); bus_cmd(8'hD0);
    check(busy_cnt == 0, "R9 abort in address phase", busy_cnt, 0);
    bus_cmd(8'h60); bus_addr(8'hC0); bus_addr(8'h00); bus_addr(8'h00);
    bus_cmd(8'h70); bus_cmd(8'hD0);
    check(busy_cnt == 0, "R9 abort in confirm slot", busy_cnt, 0);
    peek(3 * WPB, 3 * WPB * 7 + 3, "R9 block 3 untouched");

    // R5 R6: erase block 3 at max time, traffic while busy
    start_erase(8'hC0, 8'h00, 8'h00, 15);
    bus_cmd(8'h70);
    check(io_out == 8'h01, "R6 bit6 low while busy", int'(io_out), 'h01);
    bus_cmd(8'h60); bus_addr(8'h00); bus_cmd(8'hD0); bus_cmd(8'h00);
    check(rdy == 1'b0, "R5 still busy", int'(rdy), 0);
    check(io_out == 8'h01, "R5 selection kept", int'(io_out), 'h01);
    wait_ready();
    check(busy_cnt == 15, "R6 busy length 15", busy_cnt, 15);
    check(io_out == 8'h40, "R6 R8 status after pass", int'(io_out), 'h40);
    peek(3 * WPB + 2, 255, "R4 block 3 filled");

    // R10: reset command cancels a running erase on block 0
    start_erase(8'h00, 8'h00, 8'h00, 12);
    bus_cmd(8'hFF);
    check(rdy == 1'b1, "R10 ready after reset cmd", int'(rdy), 1);
    repeat (14) tick();
    peek(1, 1 * 7 + 3, "R10 cancelled erase keeps data");
    bus_cmd(8'h70);
    check(io_out == 8'h40, "R10 status after reset cmd", int'(io_out), 'h40);

    // R11: we held high, bytes change with no new edge
    busy_cnt = 0;
    cle = 1'b1; io_in = 8'h70; we = 1'b1; tick();
    io_in = 8'h60; tick(); tick();
    we = 1'b0; cle = 1'b0; tick();
    bus_addr(8'h80); bus_addr(8'h00); bus_addr(8'h00); bus_cmd(8'hD0);
    check(busy_cnt == 0, "R11 no arm without edge", busy_cnt, 0);
    check(io_out == 8'h00, "R11 R7 D0 in idle deselects", int'(io_out), 0);

    // R6: zero time counts as one cycle, block 2 passes
    start_erase(8'hBF, 8'h00, 8'h00, 0);
    wait_ready();
    check(busy_cnt == 1, "R6 zero time is one cycle", busy_cnt, 1);
    peek(2 * WPB + 3, 255, "R4 block 2 filled");

    repeat (4) tick();
    summary();
    $finish;
  end

endmodule